// File: doc/BRIEF.md
# Framebuffer Rectangle Fill and Copy Engine

This block draws into a linear framebuffer held in a word-wide memory. A command names an operation, a target rectangle and, for copies, a source corner. The engine turns it into a stream of byte reads and byte writes. Each pixel sits at byte address `bpp * x + stride * y`, and a row covers `bpp * w` bytes. For copies it picks the row order, and for same-row copies the byte order, so that overlapping source and target regions come out as if the source had been read in full before any write.

Each command ends by recording its target rectangle in a power-of-two ring of damaged rectangles. A later flush drains the ring oldest first. Each drained rectangle is clipped to the current screen size and presented for one cycle on the update outputs. A flush with the invalidate input set throws the pending entries away and emits none of them, because the whole screen is going to be redrawn anyway.

Top module: `fb_blit_engine`

## Requirements
- R1: Every memory access addresses byte `bpp * x + stride * y + k`, where k is the byte offset within the row. The port carries the word address (byte address shifted right by 2), asserts only the byte enable for lane `addr[1:0]`, and sets all four byte lanes of the write data to the same byte.
- R2: A fill (op code 1) sets every byte of the target rectangle. The byte at offset k within a pixel takes colour bits `[8k+7:8k]` (little-endian). Bytes outside the rectangle keep their values.
- R3: A copy (op code 2) leaves the target holding the source as it was before the copy, for any vertical overlap. When the target row is below the source row (target y greater than source y), rows are processed from the last row upward. Otherwise they are processed from the first row down. Every byte write of a copy follows the read of its source byte in the cycle before.
- R4: A copy with equal source and target y and target x greater than source x moves each row's bytes from right to left, so a rightward shift within a row is preserved.
- R5: `busy` rises in the cycle after a command is accepted (`cmd_valid` while `cmd_ready`) and stays high for exactly n+1 cycles for a fill, 2n+1 for a copy and 1 for an update-only command, where n = bpp·w·h. Commands presented while busy are ignored.
- R6: Each accepted command records its target rectangle (x, y, w, h) in the ring, exactly once. This holds for update-only commands (op 0 or 3) and for zero-sized ones, which touch no memory.
- R7: A flush without invalidate emits the ring entries oldest first, one per cycle. The first entry appears in the cycle after the flush is sampled, and emission stops when the ring is empty.
- R8: A flush with invalidate set empties the ring and emits nothing.
- R9: On emission, a negative origin is moved to 0 and its magnitude is taken from the size. A size that is still negative becomes 0.
- R10: On emission, a rectangle that reaches past the screen width or height is trimmed so that origin plus size equals that limit. An origin beyond the limit becomes the limit, with size 0.
- R11: Recording into a full ring discards its oldest entry, so a drain returns the newest DEPTH rectangles.
- R12: After reset the engine is idle and ready, makes no memory access, and the ring is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4, latched at acceptance |
| cfg_stride | input | STRIDE_W | Line stride in bytes, latched at acceptance |
| scr_w | input | COORD_W | Screen width used to trim emitted rectangles |
| scr_h | input | COORD_W | Screen height used to trim emitted rectangles |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 2 | 0 update-only, 1 fill, 2 copy, 3 update-only |
| cmd_x | input | COORD_W | Target x (signed for update-only) |
| cmd_y | input | COORD_W | Target y |
| cmd_sx | input | COORD_W | Copy source x |
| cmd_sy | input | COORD_W | Copy source y |
| cmd_w | input | COORD_W | Width in pixels |
| cmd_h | input | COORD_W | Height in rows |
| cmd_colour | input | 32 | Fill colour, little-endian per pixel |
| busy | output | 1 | Command in progress |
| mem_rd | output | 1 | Read request; data is returned the next cycle |
| mem_wr | output | 1 | Write request |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| flush | input | 1 | Start draining the ring |
| inval | input | 1 | With flush: discard the ring contents |
| upd_valid | output | 1 | Emitted rectangle valid |
| upd_x | output | COORD_W | Emitted x |
| upd_y | output | COORD_W | Emitted y |
| upd_w | output | COORD_W | Emitted width |
| upd_h | output | COORD_W | Emitted height |

## Verification
The assertions check on every cycle that busy follows acceptance, that no memory access occurs while idle, that each copy write follows a read, that each command records exactly one entry, that the ring never holds more than its depth, that an invalidating flush emits nothing, and that every emitted rectangle lies within the screen width. Only the bench's scenarios can show that the memory ends up with the right bytes for every overlap direction and pixel size, that drained rectangles come out in order with the right clipping, and that the ring keeps the newest entries when it overflows. The bench compares the whole memory against an arithmetic model after every command, and compares every drain against a queue model.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    OP_UPDATE = 2'd0,
    OP_FILL   = 2'd1,
    OP_COPY   = 2'd2,
    OP_RSVD   = 2'd3
  } blit_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_LOG
  } blit_state_e;
endpackage

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int COORD_W  = 12,
  parameter int STRIDE_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             cfg_bpp,
  input  logic [STRIDE_W-1:0]    cfg_stride,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [COORD_W-1:0]     cmd_x,
  input  logic [COORD_W-1:0]     cmd_y,
  input  logic [COORD_W-1:0]     cmd_sx,
  input  logic [COORD_W-1:0]     cmd_sy,
  input  logic [COORD_W-1:0]     cmd_w,
  input  logic [COORD_W-1:0]     cmd_h,
  input  logic [31:0]            cmd_colour,
  output logic                   busy,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic [ADDR_W-3:0]      mem_addr,
  output logic [3:0]             mem_be,
  output logic [31:0]            mem_wdata,
  input  logic [31:0]            mem_rdata,
  output logic                   log_valid,
  output logic [4*COORD_W-1:0]   log_rect
);
  localparam int RB_W = COORD_W + 3;
  localparam int PW   = STRIDE_W + COORD_W + 2;

  function automatic logic [ADDR_W-1:0] byte_addr(
    input logic [2:0] bpp, input logic [STRIDE_W-1:0] stride,
    input logic [COORD_W-1:0] x, input logic [COORD_W-1:0] y,
    input logic [RB_W-1:0] off);
    logic [PW-1:0] a;
    a = PW'(bpp) * PW'(x) + PW'(stride) * PW'(y) + PW'(off);
    return a[ADDR_W-1:0];
  endfunction

  blit_state_e          st;
  blit_op_e             op_q;
  logic [2:0]           bpp_q;
  logic [STRIDE_W-1:0]  stride_q;
  logic [COORD_W-1:0]   x_q, y_q, sx_q, sy_q, w_q, h_q, ridx;
  logic [31:0]          colour_q;
  logic [RB_W-1:0]      cidx, rb, cb;
  logic [1:0]           pb;
  logic                 bottom_up, rtl;
  logic [COORD_W-1:0]   ry_dst, ry_src;
  logic [ADDR_W-1:0]    src_a, dst_a;
  logic [7:0]           wbyte;
  logic                 last_col, last_row, accept;

  assign rb       = RB_W'(bpp_q) * RB_W'(w_q);
  assign last_col = (cidx == rb - 1'b1);
  assign last_row = (ridx == h_q - 1'b1);
  assign ry_dst   = bottom_up ? (y_q + h_q - 1'b1 - ridx) : (y_q + ridx);
  assign ry_src   = bottom_up ? (sy_q + h_q - 1'b1 - ridx) : (sy_q + ridx);
  assign cb       = rtl ? (rb - 1'b1 - cidx) : cidx;
  assign dst_a    = byte_addr(bpp_q, stride_q, x_q, ry_dst, cb);
  assign src_a    = byte_addr(bpp_q, stride_q, sx_q, ry_src, cb);
  assign wbyte    = (op_q == OP_FILL) ? colour_q[{pb, 3'b000} +: 8]
                                      : mem_rdata[{src_a[1:0], 3'b000} +: 8];

  assign busy      = (st != ST_IDLE);
  assign accept    = (st == ST_IDLE) && cmd_valid;
  assign mem_rd    = (st == ST_READ);
  assign mem_wr    = (st == ST_WRITE);
  assign mem_addr  = mem_rd ? src_a[ADDR_W-1:2] : dst_a[ADDR_W-1:2];
  assign mem_be    = 4'b0001 << dst_a[1:0];
  assign mem_wdata = {4{wbyte}};
  assign log_valid = (st == ST_LOG);
  assign log_rect  = {x_q, y_q, w_q, h_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      op_q <= OP_UPDATE;
      bpp_q <= 3'd1;
      stride_q <= '0;
      {x_q, y_q, sx_q, sy_q, w_q, h_q} <= '0;
      colour_q <= '0;
      ridx <= '0;
      cidx <= '0;
      pb <= '0;
      bottom_up <= 1'b0;
      rtl <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          op_q <= blit_op_e'(cmd_op);
          bpp_q <= cfg_bpp;
          stride_q <= cfg_stride;
          {x_q, y_q, sx_q, sy_q, w_q, h_q} <= {cmd_x, cmd_y, cmd_sx, cmd_sy, cmd_w, cmd_h};
          colour_q <= cmd_colour;
          ridx <= '0;
          cidx <= '0;
          pb <= '0;
          bottom_up <= (cmd_op == OP_COPY) && (cmd_sy < cmd_y);
          rtl <= (cmd_op == OP_COPY) && (cmd_sy == cmd_y) && (cmd_sx < cmd_x);
          if (cmd_w == '0 || cmd_h == '0) st <= ST_LOG;
          else if (cmd_op == OP_FILL)     st <= ST_WRITE;
          else if (cmd_op == OP_COPY)     st <= ST_READ;
          else                            st <= ST_LOG;
        end
        ST_READ: st <= ST_WRITE;
        ST_WRITE: begin
          if (!last_col) begin
            cidx <= cidx + 1'b1;
            pb <= (3'(pb) == bpp_q - 3'd1) ? 2'd0 : pb + 2'd1;
            st <= (op_q == OP_COPY) ? ST_READ : ST_WRITE;
          end else if (!last_row) begin
            cidx <= '0;
            pb <= '0;
            ridx <= ridx + 1'b1;
            st <= (op_q == OP_COPY) ? ST_READ : ST_WRITE;
          end else begin
            st <= ST_LOG;
          end
        end
        ST_LOG: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));
  assert_read_before_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && op_q == OP_COPY) |-> $past(mem_rd));
  assert_log_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |=> !log_valid);
endmodule

// File: rtl/dirty_ring.sv
module dirty_ring #(
  parameter int DEPTH   = 512,
  parameter int COORD_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [4*COORD_W-1:0] push_rect,
  input  logic                 flush,
  input  logic                 inval,
  input  logic [COORD_W-1:0]   scr_w,
  input  logic [COORD_W-1:0]   scr_h,
  output logic                 upd_valid,
  output logic [COORD_W-1:0]   upd_x,
  output logic [COORD_W-1:0]   upd_y,
  output logic [COORD_W-1:0]   upd_w,
  output logic [COORD_W-1:0]   upd_h
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CW2   = COORD_W + 2;

  function automatic logic [2*COORD_W-1:0] clip_axis(
    input logic [COORD_W-1:0] pos, input logic [COORD_W-1:0] len,
    input logic [COORD_W-1:0] lim);
    logic signed [CW2-1:0] p, l, m;
    p = {{2{pos[COORD_W-1]}}, pos};
    l = {{2{len[COORD_W-1]}}, len};
    m = {2'b00, lim};
    if (p < 0) begin
      l = l + p;
      p = '0;
    end
    if (l < 0) l = '0;
    if (p + l > m) begin
      if (p > m) p = m;
      l = m - p;
    end
    return {p[COORD_W-1:0], l[COORD_W-1:0]};
  endfunction

  logic [4*COORD_W-1:0] store [DEPTH];
  logic [IDX_W:0]       head, tail, count;
  logic                 empty, full, draining, pop, wipe;
  logic [4*COORD_W-1:0] rd_rect;

  assign count   = head - tail;
  assign empty   = (count == '0);
  assign full    = (count == (IDX_W+1)'(DEPTH));
  assign wipe    = flush && inval;
  assign pop     = !wipe && (draining || flush) && !empty;
  assign rd_rect = store[tail[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (push) store[head[IDX_W-1:0]] <= push_rect;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      draining <= 1'b0;
      upd_valid <= 1'b0;
      {upd_x, upd_w, upd_y, upd_h} <= '0;
    end else begin
      if (push) head <= head + 1'b1;
      if (wipe)                  tail <= head;
      else if (pop)              tail <= tail + 1'b1;
      else if (push && full)     tail <= tail + 1'b1;
      if (wipe)       draining <= 1'b0;
      else if (flush) draining <= 1'b1;
      else if (empty) draining <= 1'b0;
      upd_valid <= pop;
      if (pop) begin
        {upd_x, upd_w} <= clip_axis(rd_rect[4*COORD_W-1:3*COORD_W],
                                    rd_rect[2*COORD_W-1:COORD_W], scr_w);
        {upd_y, upd_h} <= clip_axis(rd_rect[3*COORD_W-1:2*COORD_W],
                                    rd_rect[COORD_W-1:0], scr_h);
      end
    end
  end

  assert_occupancy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (IDX_W+1)'(DEPTH));
  assert_inval_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !upd_valid);
  assert_trim_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ({1'b0, upd_x} + {1'b0, upd_w}) <= {1'b0, $past(scr_w)});
endmodule

// File: rtl/fb_blit_engine.sv
module fb_blit_engine #(
  parameter int ADDR_W     = 20,
  parameter int COORD_W    = 12,
  parameter int STRIDE_W   = 16,
  parameter int RING_DEPTH = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg_bpp,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [COORD_W-1:0]  scr_w,
  input  logic [COORD_W-1:0]  scr_h,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [COORD_W-1:0]  cmd_x,
  input  logic [COORD_W-1:0]  cmd_y,
  input  logic [COORD_W-1:0]  cmd_sx,
  input  logic [COORD_W-1:0]  cmd_sy,
  input  logic [COORD_W-1:0]  cmd_w,
  input  logic [COORD_W-1:0]  cmd_h,
  input  logic [31:0]         cmd_colour,
  output logic                busy,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [3:0]          mem_be,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  input  logic                flush,
  input  logic                inval,
  output logic                upd_valid,
  output logic [COORD_W-1:0]  upd_x,
  output logic [COORD_W-1:0]  upd_y,
  output logic [COORD_W-1:0]  upd_w,
  output logic [COORD_W-1:0]  upd_h
);
  logic                 log_valid;
  logic [4*COORD_W-1:0] log_rect;

  assign cmd_ready = !busy;

  blit_seq #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .STRIDE_W(STRIDE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_bpp(cfg_bpp), .cfg_stride(cfg_stride),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_x(cmd_x), .cmd_y(cmd_y),
    .cmd_sx(cmd_sx), .cmd_sy(cmd_sy), .cmd_w(cmd_w), .cmd_h(cmd_h),
    .cmd_colour(cmd_colour), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .log_valid(log_valid), .log_rect(log_rect)
  );

  dirty_ring #(.DEPTH(RING_DEPTH), .COORD_W(COORD_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(log_valid), .push_rect(log_rect),
    .flush(flush), .inval(inval), .scr_w(scr_w), .scr_h(scr_h),
    .upd_valid(upd_valid), .upd_x(upd_x), .upd_y(upd_y),
    .upd_w(upd_w), .upd_h(upd_h)
  );
endmodule

// File: tb/tb_fb_blit_engine.sv
module tb_fb_blit_engine;
  localparam int AW = 12, CW = 12, SW = 8, DEP = 4, NB = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_bpp = 3'd1;
  logic [SW-1:0] cfg_stride = 8'd48;
  logic [CW-1:0] scr_w = 12'd2000, scr_h = 12'd2000;
  logic cmd_valid = 1'b0, cmd_ready, busy, mem_rd, mem_wr, flush = 1'b0, inval = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [CW-1:0] cmd_x = '0, cmd_y = '0, cmd_sx = '0, cmd_sy = '0, cmd_w = '0, cmd_h = '0;
  logic [31:0] cmd_colour = '0, mem_wdata, mem_rdata = '0;
  logic [AW-3:0] mem_addr;
  logic [3:0] mem_be;
  logic upd_valid;
  logic [CW-1:0] upd_x, upd_y, upd_w, upd_h;

  fb_blit_engine #(.ADDR_W(AW), .COORD_W(CW), .STRIDE_W(SW), .RING_DEPTH(DEP)) dut (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [NB/4];
  logic [7:0]  refm [NB];
  always @(posedge clk) begin
    if (mem_wr)
      for (int b = 0; b < 4; b++) if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  int checks = 0, fails = 0;
  int qx[$], qy[$], qw[$], qh[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_push(input int x, y, w, h);
    if (qx.size() == DEP) begin
      void'(qx.pop_front()); void'(qy.pop_front());
      void'(qw.pop_front()); void'(qh.pop_front());
    end
    qx.push_back(x); qy.push_back(y); qw.push_back(w); qh.push_back(h);
  endtask

  function automatic void exp_clip(input int p, l, lim, output int np, output int nl);
    int a, e, r;
    a = (p < 0) ? 0 : p;
    r = l + ((p < 0) ? p : 0);
    e = a + ((r < 0) ? 0 : r);
    np = (a > lim) ? lim : a;
    e = (e > lim) ? lim : e;
    nl = (e - np < 0) ? 0 : e - np;
  endfunction

  task automatic mem_compare(input string req);
    int bad = 0, fa = 0, fe = 0;
    for (int i = 0; i < NB; i++)
      if (mem[i/4][8*(i%4) +: 8] !== refm[i]) begin
        if (bad == 0) begin fa = mem[i/4][8*(i%4) +: 8]; fe = refm[i]; end
        bad++;
      end
    check(bad == 0, req, fa, fe);
  endtask

  // Drain with or without invalidate; compare emitted rectangles with the queue model (R7, R9, R10).
  task automatic drain(input bit inv, input string req);
    int n = 0, ex, ew, ey, eh;
    @(negedge clk); flush = 1'b1; inval = inv;
    @(negedge clk); flush = 1'b0; inval = 1'b0;
    if (inv) begin qx.delete(); qy.delete(); qw.delete(); qh.delete(); end
    while (upd_valid && n < DEP + 2) begin
      if (n < qx.size()) begin
        exp_clip(qx[n], qw[n], int'(scr_w), ex, ew);
        exp_clip(qy[n], qh[n], int'(scr_h), ey, eh);
        check(int'(upd_x) == ex && int'(upd_w) == ew, {req, " x/w"}, int'(upd_x)*10000 + int'(upd_w), ex*10000 + ew);
        check(int'(upd_y) == ey && int'(upd_h) == eh, {req, " y/h"}, int'(upd_y)*10000 + int'(upd_h), ey*10000 + eh);
      end
      n++;
      @(negedge clk);
    end
    check(n == qx.size(), {req, " entry count"}, n, qx.size());
    qx.delete(); qy.delete(); qw.delete(); qh.delete();
  endtask

  task automatic run_cmd(input int op, x, y, sx, sy, w, h, input logic [31:0] col, input bit poke);
    int bpp = int'(cfg_bpp), st = int'(cfg_stride), n, exp_len, len;
    logic [7:0] tmp [NB];
    @(negedge clk);
    cmd_op = 2'(op); cmd_x = CW'(x); cmd_y = CW'(y); cmd_sx = CW'(sx); cmd_sy = CW'(sy);
    cmd_w = CW'(w); cmd_h = CW'(h); cmd_colour = col; cmd_valid = 1'b1;
    check(cmd_ready == 1'b1, "R5 ready before command", int'(cmd_ready), 1);
    @(negedge clk); cmd_valid = 1'b0;
    check(busy == 1'b1, "R5 busy after accept", int'(busy), 1);
    len = 1;
    if (poke) begin
      cmd_op = 2'd1; cmd_x = 12'd0; cmd_y = 12'd0; cmd_w = 12'd2; cmd_h = 12'd2;
      cmd_colour = 32'hA5A5A5A5; cmd_valid = 1'b1;
      @(negedge clk); cmd_valid = 1'b0;
      if (busy) len++;
    end
    while (busy && len < 5000) begin @(negedge clk); if (busy) len++; end
    n = (w > 0 && h > 0) ? bpp * w * h : 0;
    exp_len = (op == 1) ? n + 1 : (op == 2) ? 2 * n + 1 : 1;
    check(len == exp_len, "R5 busy length", len, exp_len);
    if (op == 1 && n > 0)
      for (int r = 0; r < h; r++)
        for (int b = 0; b < bpp * w; b++)
          refm[bpp * x + st * (y + r) + b] = col[8 * (b % bpp) +: 8];
    if (op == 2 && n > 0) begin
      for (int i = 0; i < NB; i++) tmp[i] = refm[i];
      for (int r = 0; r < h; r++)
        for (int b = 0; b < bpp * w; b++)
          refm[bpp * x + st * (y + r) + b] = tmp[bpp * sx + st * (sy + r) + b];
    end
    model_push(x, y, w, h);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      refm[i] = 8'((i * 7 + 3) & 255);
      mem[i/4][8*(i%4) +: 8] = 8'((i * 7 + 3) & 255);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(busy == 1'b0 && cmd_ready == 1'b1, "R12 idle after reset", int'(busy), 0);
    check(mem_rd == 1'b0 && mem_wr == 1'b0, "R12 no access after reset", int'(mem_rd | mem_wr), 0);
    check(upd_valid == 1'b0, "R12 no update after reset", int'(upd_valid), 0);
    drain(1'b0, "R12 ring empty");

    // R1 R2: fill sweep over pixel size and rectangle shape
    for (int b = 1; b <= 4; b++) begin
      cfg_bpp = 3'(b);
      for (int w = 1; w <= 3; w++)
        for (int h = 1; h <= 3; h++) begin
          run_cmd(1, w + 1, h + 2, 0, 0, w, h, 32'h11223344 + 32'(b * 16 + w * 4 + h), 1'b0);
          mem_compare("R2 R1 fill contents");
          drain(1'b0, "R6 fill logged");
        end
    end

    // R3 R4: copy sweep over every overlap direction
    for (int b = 1; b <= 4; b++) begin
      cfg_bpp = 3'(b);
      for (int dy = -2; dy <= 2; dy++)
        for (int dx = -2; dx <= 2; dx++) begin
          run_cmd(2, 4 + dx, 4 + dy, 4, 4, 3, 3, 32'h0, 1'b0);
          mem_compare((dy == 0) ? "R4 same-row copy" : "R3 overlapping copy");
          drain(1'b0, "R6 copy logged");
        end
    end

    // R5: command presented while busy is ignored
    cfg_bpp = 3'd2;
    run_cmd(1, 9, 12, 0, 0, 2, 2, 32'hCAFE0B0E, 1'b1);
    mem_compare("R5 ignored command left memory");
    drain(1'b0, "R5 single logged entry");

    // R6: zero-sized and reserved-op commands touch nothing but are logged
    run_cmd(1, 3, 3, 0, 0, 0, 4, 32'hFFFFFFFF, 1'b0);
    run_cmd(3, 5, 6, 0, 0, 7, 8, 32'h0, 1'b0);
    mem_compare("R6 zero size no write");
    drain(1'b0, "R6 zero size and reserved logged");

    // R9 R10: clipping sweep on a small screen
    scr_w = 12'd20; scr_h = 12'd10;
    for (int x = -4; x <= 24; x++)
      for (int w = -2; w <= 8; w += 2) begin
        run_cmd(0, x, 3, 0, 0, w, 4, 32'h0, 1'b0);
        drain(1'b0, (x < 0 || w < 0) ? "R9 negative clip x" : "R10 trim x");
      end
    for (int y = -3; y <= 13; y++)
      for (int h = -1; h <= 7; h += 2) begin
        run_cmd(0, 2, y, 0, 0, 5, h, 32'h0, 1'b0);
        drain(1'b0, (y < 0 || h < 0) ? "R9 negative clip y" : "R10 trim y");
      end

    // R11: overflow keeps newest DEPTH entries; R7 order
    for (int k = 0; k < DEP + 2; k++) run_cmd(0, k, k + 1, 0, 0, 2, 1, 32'h0, 1'b0);
    drain(1'b0, "R11 R7 overflow drain order");

    // R8: invalidate flush discards pending entries
    run_cmd(0, 1, 1, 0, 0, 3, 3, 32'h0, 1'b0);
    run_cmd(0, 2, 2, 0, 0, 3, 3, 32'h0, 1'b0);
    drain(1'b1, "R8 invalidate emits nothing");
    drain(1'b0, "R8 ring empty after invalidate");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule